// File: doc/BRIEF.md
# Programmable Routing Switch Tile

This block is one interconnect tile of an island-style programmable fabric. It sits where a horizontal and a vertical routing channel cross. Each of its four sides (north, east, south, west) carries `W` incoming and `W` outgoing tracks. The tile also serves a neighbouring logic block. Logic-block output pins can be placed onto tracks, and logic-block input pins can be fed from tracks. Every outgoing wire is the output of a small multiplexer. The select code of that multiplexer lives in volatile configuration storage. Because a multiplexer picks exactly one source, no outgoing track can ever be driven by two nets at once.

The configuration storage is a serial scan chain. Bits enter on `cfgIn` while `cfgEn` is high, the first bit shifted becoming bit 0 of the configuration image. Bits leave on `cfgOut`, so many tiles can be daisy-chained. The storage is not cleared at power-up, so the routed outputs are held at 0 until a full image has been shifted in since reset.

Three elaboration parameters fix which connections exist at all:
- `FS` is the switch-box flexibility: how many other sides a track can reach.
- `FC_IN` sets how many tracks per side can reach each input pin.
- `FC_OUT` sets how many tracks per side each output pin can reach.

Top module: `routing_switch_tile`

## Requirements
- R1: While `rstN` is low, and right after reset, `cfgDone` is 0 and `trkOut` and `lbIn` are all 0, whatever values `trkIn` and `lbOut` carry.
- R2: Each rising clock edge with `cfgEn` high shifts the chain by one bit. The first bit shifted in ends at bit 0 of the image. `cfgOut` shows the current bit 0, so while a new image is shifted in, `cfgOut` before shift j equals bit j of the previous image.
- R3: `cfgDone` rises on the edge that completes the `CFG_BITS`-th shift since reset (64 with default parameters). Cycles with `cfgEn` low are not counted. Once high, `cfgDone` stays high until reset.
- R4: While `cfgDone` is 0, every bit of `trkOut` and `lbIn` is 0.
- R5: Track bits are indexed as side*W+index, with sides north=0, east=1, south=2, west=3. The select code of outgoing track (side s, index i) is read from image bits [(s*W+i)*3 +: 3]. Code 0 drives 0. Code c in 1..FS drives incoming track index i of side (s+c) mod 4, so tracks only ever connect to the same index.
- R6: Track code FS+1+p (4 or 5 with defaults) selects output pin p. This takes effect only when (i−p) mod W < FC_OUT; otherwise the track is driven to 0. Track codes above FS+NUM_OPIN drive 0.
- R7: The select code of input pin q is read from image bits [16*W-... concretely 48 + q*4 +: 4]. Code 0 drives 0. Code c in 1..4*FC_IN selects incoming track (side (c−1)/FC_IN, index (q + (c−1) mod FC_IN) mod W). Higher codes drive 0.
- R8: With all inputs 0, every routed output is 0 in any configuration. A path never produces a 1 without a source.
- R9: With `cfgEn` low, the configuration image and `cfgOut` hold, whatever `cfgIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Active-low reset of the load counter |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out, for daisy-chaining |
| cfgDone | output | 1 | Full image loaded since reset; enables routed outputs |
| trkIn | input | 4*W | Incoming track values, bit side*W+index |
| trkOut | output | 4*W | Outgoing track values, bit side*W+index |
| lbOut | input | NUM_OPIN | Logic-block output pins |
| lbIn | output | NUM_IPIN | Logic-block input pins |

## Verification
The hardest situation to reach from the ports is the cross product of select codes and input values. This includes output-pin codes aimed at a track the pin has no wire to, and codes past the last legal source. Each of these must read 0 rather than some neighbouring source. Reaching it needs whole 64-bit images shifted through the chain. The stimulus therefore loads many random images, with every field drawn over its full binary range, and applies random track and pin values to each. While each image is loaded, the previous one streams out of `cfgOut` and is compared bit by bit. A split load with idle gaps pins down the exact edge on which `cfgDone` rises.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int NUM_SIDES = 4;

  typedef struct packed {
    logic shiftEn;
    logic cfgValid;
  } cfgStrobe_t;

  function automatic int trkSelCount(int fs, int numOpin);
    return fs + numOpin + 1;
  endfunction

  function automatic int pinSelCount(int fcIn);
    return NUM_SIDES * fcIn + 1;
  endfunction

  function automatic int chainLen(int w, int numIpin, int numOpin, int fcIn, int fs);
    return NUM_SIDES * w * $clog2(trkSelCount(fs, numOpin)) +
           numIpin * $clog2(pinSelCount(fcIn));
  endfunction

endpackage

// File: rtl/rsb_cfg_ctrl.sv
module rsb_cfg_ctrl #(
  parameter int CFG_BITS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEn,
  output rsb_pkg::cfgStrobe_t strobe
);
  localparam int CNT_W = $clog2(CFG_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             loaded;

  assign loaded = (bitCnt == FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (cfgEn && !loaded) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign strobe.shiftEn  = cfgEn;
  assign strobe.cfgValid = loaded;
endmodule

// File: rtl/rsb_cfg_chain.sv
module rsb_cfg_chain #(
  parameter int CFG_BITS = 64
) (
  input  logic                clk,
  input  rsb_pkg::cfgStrobe_t strobe,
  input  logic                cfgIn,
  output logic                cfgOut,
  output logic [CFG_BITS-1:0] cfgImage
);
  logic [CFG_BITS-1:0] cells;

  always_ff @(posedge clk) begin
    if (strobe.shiftEn) begin
      if (CFG_BITS > 1) begin
        cells <= {cfgIn, cells[CFG_BITS-1:1]};
      end else begin
        cells <= cfgIn;
      end
    end
  end

  assign cfgOut   = cells[0];
  assign cfgImage = cells;
endmodule

// File: rtl/rsb_route_fabric.sv
module rsb_route_fabric #(
  parameter int W        = 4,
  parameter int NUM_IPIN = 4,
  parameter int NUM_OPIN = 2,
  parameter int FC_IN    = 2,
  parameter int FC_OUT   = 2,
  parameter int FS       = 3
) (
  input  logic [rsb_pkg::chainLen(W, NUM_IPIN, NUM_OPIN, FC_IN, FS)-1:0] cfgImage,
  input  logic                                   cfgValid,
  input  logic [rsb_pkg::NUM_SIDES*W-1:0]        trkIn,
  input  logic [NUM_OPIN-1:0]                    lbOut,
  output logic [rsb_pkg::NUM_SIDES*W-1:0]        trkOut,
  output logic [NUM_IPIN-1:0]                    lbIn
);
  localparam int SIDES    = rsb_pkg::NUM_SIDES;
  localparam int TSEL_N   = rsb_pkg::trkSelCount(FS, NUM_OPIN);
  localparam int TSEL_W   = $clog2(TSEL_N);
  localparam int PSEL_N   = rsb_pkg::pinSelCount(FC_IN);
  localparam int PSEL_W   = $clog2(PSEL_N);
  localparam int TRK_BITS = SIDES * W * TSEL_W;

  // switch box plus output connection box: one mux per outgoing track
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar i = 0; i < W; i++) begin : g_trk
      logic [TSEL_W-1:0] sel;
      logic [TSEL_N-1:0] cand;
      logic              routed;

      assign sel     = cfgImage[(s*W+i)*TSEL_W +: TSEL_W];
      assign cand[0] = 1'b0;

      for (genvar h = 1; h <= FS; h++) begin : g_hop
        assign cand[h] = trkIn[((s + h) % SIDES)*W + i];
      end

      for (genvar p = 0; p < NUM_OPIN; p++) begin : g_opin
        if ((((i - p) % W) + W) % W < FC_OUT) begin : g_wired
          assign cand[FS+1+p] = lbOut[p];
        end else begin : g_absent
          assign cand[FS+1+p] = 1'b0;
        end
      end

      always_comb begin
        routed = 1'b0;
        for (int c = 1; c < TSEL_N; c++) begin
          if (sel == TSEL_W'(c)) routed = cand[c];
        end
      end

      assign trkOut[s*W+i] = cfgValid & routed;
    end
  end

  // input connection box: one mux per logic-block input pin
  for (genvar q = 0; q < NUM_IPIN; q++) begin : g_ipin
    logic [PSEL_W-1:0] sel;
    logic [PSEL_N-1:0] cand;
    logic              routed;

    assign sel     = cfgImage[TRK_BITS + q*PSEL_W +: PSEL_W];
    assign cand[0] = 1'b0;

    for (genvar s = 0; s < SIDES; s++) begin : g_src_side
      for (genvar k = 0; k < FC_IN; k++) begin : g_tap
        assign cand[1 + s*FC_IN + k] = trkIn[s*W + (q + k) % W];
      end
    end

    always_comb begin
      routed = 1'b0;
      for (int c = 1; c < PSEL_N; c++) begin
        if (sel == PSEL_W'(c)) routed = cand[c];
      end
    end

    assign lbIn[q] = cfgValid & routed;
  end
endmodule

// File: rtl/routing_switch_tile.sv
module routing_switch_tile #(
  parameter int W        = 4,
  parameter int NUM_IPIN = 4,
  parameter int NUM_OPIN = 2,
  parameter int FC_IN    = 2,
  parameter int FC_OUT   = 2,
  parameter int FS       = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgEn,
  input  logic                           cfgIn,
  output logic                           cfgOut,
  output logic                           cfgDone,
  input  logic [rsb_pkg::NUM_SIDES*W-1:0] trkIn,
  output logic [rsb_pkg::NUM_SIDES*W-1:0] trkOut,
  input  logic [NUM_OPIN-1:0]            lbOut,
  output logic [NUM_IPIN-1:0]            lbIn
);
  localparam int CFG_BITS = rsb_pkg::chainLen(W, NUM_IPIN, NUM_OPIN, FC_IN, FS);

  rsb_pkg::cfgStrobe_t strobe;
  logic [CFG_BITS-1:0] cfgImage;

  rsb_cfg_ctrl #(.CFG_BITS(CFG_BITS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cfgEn  (cfgEn),
    .strobe (strobe)
  );

  rsb_cfg_chain #(.CFG_BITS(CFG_BITS)) chain_i (
    .clk      (clk),
    .strobe   (strobe),
    .cfgIn    (cfgIn),
    .cfgOut   (cfgOut),
    .cfgImage (cfgImage)
  );

  rsb_route_fabric #(
    .W(W), .NUM_IPIN(NUM_IPIN), .NUM_OPIN(NUM_OPIN),
    .FC_IN(FC_IN), .FC_OUT(FC_OUT), .FS(FS)
  ) fabric_i (
    .cfgImage (cfgImage),
    .cfgValid (strobe.cfgValid),
    .trkIn    (trkIn),
    .lbOut    (lbOut),
    .trkOut   (trkOut),
    .lbIn     (lbIn)
  );

  assign cfgDone = strobe.cfgValid;
endmodule

// File: rtl/routing_switch_tile_chk.sv
module routing_switch_tile_chk #(
  parameter int W        = 4,
  parameter int NUM_IPIN = 4,
  parameter int NUM_OPIN = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            cfgEn,
  input logic                            cfgOut,
  input logic                            cfgDone,
  input logic [rsb_pkg::NUM_SIDES*W-1:0] trkIn,
  input logic [rsb_pkg::NUM_SIDES*W-1:0] trkOut,
  input logic [NUM_OPIN-1:0]             lbOut,
  input logic [NUM_IPIN-1:0]             lbIn
);
  a_r4_gated_until_loaded: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |-> (trkOut == '0 && lbIn == '0));

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> cfgDone);

  a_r3_done_needs_shift: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDone && !cfgEn) |=> !cfgDone);

  a_r9_chain_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(cfgOut));

  a_r8_no_source_no_one: assert property (@(posedge clk) disable iff (!rstN)
    (trkIn == '0 && lbOut == '0) |-> (trkOut == '0 && lbIn == '0));
endmodule

bind routing_switch_tile routing_switch_tile_chk #(
  .W(W), .NUM_IPIN(NUM_IPIN), .NUM_OPIN(NUM_OPIN)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgOut(cfgOut), .cfgDone(cfgDone),
  .trkIn(trkIn), .trkOut(trkOut), .lbOut(lbOut), .lbIn(lbIn)
);

// File: tb/routing_switch_tile_tb_top.sv
module routing_switch_tile_tb_top;
  localparam int W   = 4;
  localparam int NIP = 4;
  localparam int NOP = 2;
  localparam int FCI = 2;
  localparam int FCO = 2;
  localparam int FS  = 3;
  localparam int TW  = 3;
  localparam int PW  = 4;
  localparam int NB  = 64;
  localparam int TB  = 48;

  logic clk = 1'b0;
  logic rstN, cfgEn, cfgIn, cfgOut, cfgDone;
  logic [4*W-1:0] trkIn, trkOut;
  logic [NOP-1:0] lbOut;
  logic [NIP-1:0] lbIn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  routing_switch_tile #(.W(W), .NUM_IPIN(NIP), .NUM_OPIN(NOP),
                        .FC_IN(FCI), .FC_OUT(FCO), .FS(FS)) dut_i (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgIn(cfgIn), .cfgOut(cfgOut),
    .cfgDone(cfgDone), .trkIn(trkIn), .trkOut(trkOut), .lbOut(lbOut), .lbIn(lbIn)
  );

  function automatic logic [4*W-1:0] expTrk(logic [NB-1:0] img, logic [4*W-1:0] tin,
                                            logic [NOP-1:0] lo);
    logic [4*W-1:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < W; i++) begin
        int code = int'(img[(s*W+i)*TW +: TW]);
        if (code >= 1 && code <= FS) begin
          r[s*W+i] = tin[((s+code)%4)*W + i];
        end else if (code > FS && code <= FS+NOP) begin
          int p = code - FS - 1;
          if ((((i-p)%W)+W)%W < FCO) r[s*W+i] = lo[p];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [NIP-1:0] expPin(logic [NB-1:0] img, logic [4*W-1:0] tin);
    logic [NIP-1:0] r = '0;
    for (int q = 0; q < NIP; q++) begin
      int code = int'(img[TB + q*PW +: PW]);
      if (code >= 1 && code <= 4*FCI) begin
        int side = (code-1) / FCI;
        int k    = (code-1) % FCI;
        r[q] = tin[side*W + (q+k)%W];
      end
    end
    return r;
  endfunction

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shiftRange(logic [NB-1:0] img, int lo, int hi,
                            bit chkOut, logic [NB-1:0] prev);
    for (int j = lo; j < hi; j++) begin
      @(negedge clk);
      if (chkOut) check(64'(cfgOut), 64'(prev[j]), "R2 cfgOut stream");
      cfgEn = 1'b1;
      cfgIn = img[j];
    end
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  task automatic applyAndCheck(logic [NB-1:0] img, logic [4*W-1:0] tin, logic [NOP-1:0] lo,
                               string tag);
    @(negedge clk);
    trkIn = tin;
    lbOut = lo;
    cfgIn = 1'($urandom);
    #2;
    check(64'(trkOut), 64'(expTrk(img, tin, lo)), {tag, " R5,R6 trkOut"});
    check(64'(lbIn), 64'(expPin(img, tin)), {tag, " R7 lbIn"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] imgA, imgB, cur, prev;
    void'($urandom(32'd2024));
    rstN = 1'b0; cfgEn = 1'b0; cfgIn = 1'b0;
    trkIn = '1; lbOut = '1;
    repeat (3) @(negedge clk);
    // R1: reset state with all inputs high
    check(64'(cfgDone), 64'd0, "R1 cfgDone in reset");
    check(64'(trkOut), 64'd0, "R1 trkOut in reset");
    check(64'(lbIn), 64'd0, "R1 lbIn in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(64'(trkOut), 64'd0, "R4 trkOut after reset");

    imgA = {$urandom, $urandom};
    imgB = {$urandom, $urandom};
    // R3: split load with idle gap
    shiftRange(imgA, 0, 30, 1'b0, '0);
    repeat (5) begin
      @(negedge clk);
      cfgIn = 1'($urandom);
    end
    check(64'(cfgDone), 64'd0, "R3 done after 30 shifts and idle");
    check(64'(lbIn), 64'd0, "R4 lbIn gated mid load");
    check(64'(trkOut), 64'd0, "R4 trkOut gated mid load");
    shiftRange(imgA, 30, 63, 1'b0, '0);
    check(64'(cfgDone), 64'd0, "R3 done after 63 shifts");
    shiftRange(imgA, 63, 64, 1'b0, '0);
    check(64'(cfgDone), 64'd1, "R3 done after 64 shifts");
    applyAndCheck(imgA, 16'hA5C3, 2'b10, "imgA");

    // R2: reload streams the old image out; R3 done stays high
    shiftRange(imgB, 0, NB, 1'b1, imgA);
    check(64'(cfgDone), 64'd1, "R3 done sticky");
    applyAndCheck(imgB, 16'h3C96, 2'b01, "imgB");

    // all-zero codes: every output 0 with all inputs high (R5, R7 code 0)
    shiftRange('0, 0, NB, 1'b1, imgB);
    applyAndCheck('0, '1, '1, "zero codes");

    // directed R6: every track selects output pin 0
    cur = '0;
    for (int t = 0; t < 4*W; t++) cur[t*TW +: TW] = 3'd4;
    shiftRange(cur, 0, NB, 1'b1, '0);
    applyAndCheck(cur, '0, 2'b01, "R6 pin0 wiring");
    applyAndCheck(cur, '1, 2'b10, "R6 pin0 low");
    prev = cur;

    // random images with full-range codes
    for (int n = 0; n < 30; n++) begin
      cur = {$urandom, $urandom};
      shiftRange(cur, 0, NB, 1'b1, prev);
      for (int v = 0; v < 12; v++) begin
        applyAndCheck(cur, 16'($urandom), 2'($urandom), "random");
      end
      // R9: cfgIn toggles with cfgEn low; routing and chain output hold
      @(negedge clk);
      check(64'(cfgOut), 64'(cur[0]), "R9 cfgOut hold");
      applyAndCheck(cur, 16'($urandom), 2'($urandom), "R9 hold");
      // R8: no source, no one
      applyAndCheck(cur, '0, '0, "R8 quiet");
      check(64'(trkOut | 16'(lbIn)), 64'd0, "R8 all outputs zero");
      prev = cur;
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule